// File: doc/BRIEF.md
# Handshaked Control-Register Port Target

This block sits on the PHY side of a narrow parallel port that gives on-chip access to diagnostic and override registers. The host shares one 16-bit input bus between address and data. It drives one of four request strobes (take address, take data, commit write, read) and waits for the target's acknowledge. Every stage is a full four-phase exchange: the strobe rises, the acknowledge rises, the strobe falls, and then the acknowledge falls.

A write uses three stages: the address is latched, then the data, then the commit copies the data latch into the addressed register. A read uses two stages: the address is latched, then the read strobe places the register value on the 16-bit output, where it stays valid for as long as the acknowledge is high. The target holds a short, parameterised list of writable registers, each with its own offset and reset value, plus a fixed identity word at offset zero. The delay before the acknowledge is programmable from one to four cycles, so that hosts can be tested against slow targets.

Top module: `crport_target`

## Requirements
- R1: After reset, `ack_o` is 0, `dout_o` is 0x0000, and both the address latch and the data latch hold 0x0000.
- R2: `ack_o` rises on the ACK_LAT-th rising clock edge after the edge that first samples a single request strobe high (ACK_LAT is 1 to 4, default 2).
- R3: While the accepted strobe stays high, `ack_o` stays high. `ack_o` falls on the first rising edge that samples that strobe low.
- R4: While a stage is in progress, other strobes are ignored. A strobe still high when `ack_o` returns low starts a new stage. When more than one strobe is high in the idle state, no stage starts.
- R5: The take-address stage (`req_addr_i`) loads `din_i` into the address latch. The take-data stage (`req_data_i`) loads `din_i` into the data latch.
- R6: The commit stage (`req_wr_i`) copies the data latch into the writable register whose offset equals the address latch. That value, or the register's reset value if it was never written, is returned by later reads.
- R7: The read stage (`req_rd_i`) drives the addressed value on `dout_o` in the same cycle that `ack_o` rises. `dout_o` stays stable until the next read stage.
- R8: Offset 0x0000 always reads the fixed identity value (default 0x3A61), and commits to it are ignored.
- R9: An offset in 0x0001..0x201F that has no register reads 0x0000. A commit to such an offset changes no register, and the stage is still acknowledged normally.
- R10: An offset above 0x201F reads 0x0000, a commit to it changes no register, and every stage to it is still acknowledged.
- R11: The address and data latches keep their values across transactions, so a commit or read stage without a new address or data stage reuses the latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| din_i | input | 16 | Shared address/data input bus |
| req_addr_i | input | 1 | Take-address strobe |
| req_data_i | input | 1 | Take-data strobe |
| req_wr_i | input | 1 | Commit-write strobe |
| req_rd_i | input | 1 | Read strobe |
| dout_o | output | 16 | Read data, valid while ack_o is high after a read stage |
| ack_o | output | 1 | Four-phase acknowledge |

## Verification
A corrupted address latch shows up at the next read: `dout_o` carries the wrong register's value or zero, in the same cycle that `ack_o` rises. A stuck or mis-counted handshake state shows up within a single stage, either as an acknowledge arriving at the wrong edge or as one that does not follow the strobe down. Decode faults on out-of-range or unimplemented offsets stay hidden until a later read of a real register, so every write in the sweep is followed by read-backs.

// File: rtl/crport_pkg.sv
package crport_pkg;

  localparam int CR_W = 16;
  typedef logic [CR_W-1:0] word_t;

  // Request bit order on the internal vector: {rd, wr, data, addr}
  typedef enum logic [1:0] {
    STG_ADDR = 2'd0,
    STG_DATA = 2'd1,
    STG_WR   = 2'd2,
    STG_RD   = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;

  function automatic logic single_req(input logic [3:0] req);
    return (req != 4'b0000) && ((req & (req - 4'd1)) == 4'b0000);
  endfunction

  function automatic stage_e stage_of(input logic [3:0] req);
    stage_e s;
    unique case (1'b1)
      req[3]:  s = STG_RD;
      req[2]:  s = STG_WR;
      req[1]:  s = STG_DATA;
      default: s = STG_ADDR;
    endcase
    return s;
  endfunction

  function automatic logic offset_valid(input word_t ofs, input word_t max_ofs);
    return ofs <= max_ofs;
  endfunction

endpackage

// File: rtl/crport_handshake.sv
module crport_handshake
  import crport_pkg::*;
#(
  parameter int ACK_LAT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] req_i,
  output logic       ack_o,
  output logic       busy_o,
  output logic       fire_o,
  output stage_e     kind_o,
  output logic       sel_req_o
);

  localparam int CW = 3;
  localparam logic [CW-1:0] LAT_C = CW'(ACK_LAT);

  hs_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  stage_e         kind_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      kind_q  <= STG_ADDR;
    end else begin
      unique case (state_q)
        HS_IDLE: begin
          if (single_req(req_i)) begin
            state_q <= HS_WAIT;
            kind_q  <= stage_of(req_i);
            cnt_q   <= CW'(1);
          end
        end
        HS_WAIT: begin
          if (cnt_q == LAT_C) state_q <= HS_ACK;
          else                cnt_q   <= cnt_q + CW'(1);
        end
        HS_ACK: begin
          if (!req_i[kind_q]) state_q <= HS_IDLE;
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assign fire_o    = (state_q == HS_WAIT) && (cnt_q == LAT_C);
  assign ack_o     = (state_q == HS_ACK);
  assign busy_o    = (state_q != HS_IDLE);
  assign kind_o    = kind_q;
  assign sel_req_o = req_i[kind_q];

endmodule

// File: rtl/crport_latch_pair.sv
module crport_latch_pair
  import crport_pkg::*;
#(
  parameter int DW = CR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  stage_e        kind_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  logic [DW-1:0] addr_q, data_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fire_i) begin
      if (kind_i == STG_ADDR) addr_q <= din_i;
      if (kind_i == STG_DATA) data_q <= din_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;

endmodule

// File: rtl/crport_regbank.sv
module crport_regbank
  import crport_pkg::*;
#(
  parameter int                   DW       = CR_W,
  parameter int                   NUM_RW   = 3,
  parameter logic [DW-1:0]        MAX_OFS  = 16'h201F,
  parameter logic [DW-1:0]        ID_VALUE = 16'h3A61,
  parameter logic [NUM_RW*DW-1:0] RW_OFS   = {16'h201F, 16'h1005, 16'h0010},
  parameter logic [NUM_RW*DW-1:0] RW_RST   = {16'hA5A5, 16'h0F0F, 16'h1234}
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [DW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NUM_RW*DW-1:0]   regs_o
);

  logic [DW-1:0]     reg_q [NUM_RW];
  logic [NUM_RW-1:0] hit;
  logic              in_range;
  logic              id_sel;

  assign in_range = offset_valid(addr_i, MAX_OFS);
  assign id_sel   = (addr_i == '0);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    assign hit[g] = in_range && !id_sel && (addr_i == RW_OFS[g*DW +: DW]);

    always_ff @(posedge clk_i) begin
      if (!rst_ni)                reg_q[g] <= RW_RST[g*DW +: DW];
      else if (wr_en_i && hit[g]) reg_q[g] <= wdata_i;
    end

    assign regs_o[g*DW +: DW] = reg_q[g];
  end

  always_comb begin
    rdata_o = id_sel ? ID_VALUE : '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (hit[i]) rdata_o = rdata_o | reg_q[i];
    end
  end

endmodule

// File: rtl/crport_target.sv
module crport_target
  import crport_pkg::*;
#(
  parameter int                   DW       = CR_W,
  parameter int                   NUM_RW   = 3,
  parameter int                   ACK_LAT  = 2,
  parameter logic [DW-1:0]        MAX_OFS  = 16'h201F,
  parameter logic [DW-1:0]        ID_VALUE = 16'h3A61,
  parameter logic [NUM_RW*DW-1:0] RW_OFS   = {16'h201F, 16'h1005, 16'h0010},
  parameter logic [NUM_RW*DW-1:0] RW_RST   = {16'hA5A5, 16'h0F0F, 16'h1234}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] din_i,
  input  logic          req_addr_i,
  input  logic          req_data_i,
  input  logic          req_wr_i,
  input  logic          req_rd_i,
  output logic [DW-1:0] dout_o,
  output logic          ack_o
);

  logic [3:0]           req_w;
  logic                 stage_fire;
  stage_e               stage_kind;
  logic                 sel_req;
  logic                 hs_busy;
  logic [DW-1:0]        addr_lat;
  logic [DW-1:0]        data_lat;
  logic [DW-1:0]        bank_rdata;
  logic [NUM_RW*DW-1:0] bank_regs;
  logic                 commit_en;
  logic [DW-1:0]        dout_q;

  assign req_w = {req_rd_i, req_wr_i, req_data_i, req_addr_i};

  crport_handshake #(.ACK_LAT(ACK_LAT)) u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_w),
    .ack_o    (ack_o),
    .busy_o   (hs_busy),
    .fire_o   (stage_fire),
    .kind_o   (stage_kind),
    .sel_req_o(sel_req)
  );

  crport_latch_pair #(.DW(DW)) u_lat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(stage_fire),
    .kind_i(stage_kind),
    .din_i (din_i),
    .addr_o(addr_lat),
    .data_o(data_lat)
  );

  assign commit_en = stage_fire && (stage_kind == STG_WR);

  crport_regbank #(
    .DW(DW), .NUM_RW(NUM_RW), .MAX_OFS(MAX_OFS), .ID_VALUE(ID_VALUE),
    .RW_OFS(RW_OFS), .RW_RST(RW_RST)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(commit_en),
    .addr_i (addr_lat),
    .wdata_i(data_lat),
    .rdata_o(bank_rdata),
    .regs_o (bank_regs)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                   dout_q <= '0;
    else if (stage_fire && stage_kind == STG_RD)   dout_q <= bank_rdata;
  end

  assign dout_o = dout_q;

endmodule

// File: rtl/crport_target_chk.sv
module crport_target_chk
  import crport_pkg::*;
#(
  parameter int            DW       = CR_W,
  parameter int            NUM_RW   = 3,
  parameter int            ACK_LAT  = 2,
  parameter logic [DW-1:0] MAX_OFS  = 16'h201F,
  parameter logic [DW-1:0] ID_VALUE = 16'h3A61
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [3:0]           req_i,
  input logic                 ack_i,
  input logic [DW-1:0]        dout_i,
  input logic                 fire_i,
  input stage_e               kind_i,
  input logic                 sel_req_i,
  input logic                 busy_i,
  input logic [DW-1:0]        addr_i,
  input logic [NUM_RW*DW-1:0] regs_i
);

  logic [2:0] wait_cnt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !busy_i) wait_cnt <= '0;
    else if (!ack_i)        wait_cnt <= wait_cnt + 3'd1;
  end

  p_ack_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_i) |-> (wait_cnt == 3'(ACK_LAT)));

  p_ack_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && sel_req_i) |=> ack_i);

  p_ack_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !sel_req_i) |=> !ack_i);

  p_no_multi_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && ($countones(req_i) != 1)) |=> !busy_i);

  p_kind_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(kind_i));

  p_dout_steady_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && $past(ack_i)) |-> $stable(dout_i));

  p_id_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && kind_i == STG_RD && addr_i == '0) |=> (dout_i == ID_VALUE));

  p_oor_commit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && kind_i == STG_WR && addr_i > MAX_OFS) |=> $stable(regs_i));

endmodule

bind crport_target crport_target_chk #(
  .DW(DW), .NUM_RW(NUM_RW), .ACK_LAT(ACK_LAT), .MAX_OFS(MAX_OFS), .ID_VALUE(ID_VALUE)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_w),
  .ack_i    (ack_o),
  .dout_i   (dout_o),
  .fire_i   (stage_fire),
  .kind_i   (stage_kind),
  .sel_req_i(sel_req),
  .busy_i   (hs_busy),
  .addr_i   (addr_lat),
  .regs_i   (bank_regs)
);

// File: tb/crport_target_tb.sv
module crport_target_tb_top;

  localparam int          LAT    = 2;
  localparam logic [15:0] ID_V   = 16'h3A61;
  localparam logic [15:0] TOP    = 16'h201F;
  localparam logic [15:0] OFS [3] = '{16'h0010, 16'h1005, 16'h201F};
  localparam logic [15:0] RSTV[3] = '{16'h1234, 16'h0F0F, 16'hA5A5};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] din = '0;
  logic        req_addr = 1'b0, req_data = 1'b0, req_wr = 1'b0, req_rd = 1'b0;
  logic [15:0] dout;
  logic        ack;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_addr, m_data;
  logic [15:0] m_reg [3];

  always #5 clk = ~clk;

  crport_target #(.ACK_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_wr_i(req_wr), .req_rd_i(req_rd),
    .dout_o(dout), .ack_o(ack)
  );

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%04h expected=0x%04h", r, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [15:0] a);
    if (a == 16'h0000) return ID_V;
    if (a > TOP) return 16'h0000;
    for (int i = 0; i < 3; i++) if (a == OFS[i]) return m_reg[i];
    return 16'h0000;
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (a == 16'h0000) return "R8";
    if (a > TOP) return "R10";
    for (int i = 0; i < 3; i++) if (a == OFS[i]) return "R6";
    return "R9";
  endfunction

  task automatic drive(input int k, input logic v);
    case (k)
      0: req_addr = v;
      1: req_data = v;
      2: req_wr   = v;
      default: req_rd = v;
    endcase
  endtask

  task automatic run_stage(input int k, input logic [15:0] v, output logic [15:0] got);
    int n;
    @(negedge clk);
    din = v;
    drive(k, 1'b1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 12);
    chk(n == LAT + 1, "R2", "ack latency", 16'(n), 16'(LAT + 1));
    got = dout;
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk(ack == 1'b1, "R3", "ack held", {15'd0, ack}, 16'd1);
      chk(dout == got, "R7", "dout stable", dout, got);
    end
    drive(k, 1'b0);
    @(negedge clk);
    chk(ack == 1'b0, "R3", "ack release", {15'd0, ack}, 16'd0);
    case (k)
      0: m_addr = v;
      1: m_data = v;
      2: if (m_addr != 16'h0000 && m_addr <= TOP)
           for (int i = 0; i < 3; i++) if (m_addr == OFS[i]) m_reg[i] = m_data;
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [15:0] g;
    run_stage(0, a, g);
    run_stage(3, 16'h0000, g);
    chk(g == m_read(a), tag, $sformatf("read 0x%04h", a), g, m_read(a));
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] g;
    run_stage(0, a, g);
    run_stage(1, d, g);
    run_stage(2, 16'h0000, g);
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < 3; i++) do_read(OFS[i], tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] g;
    logic [15:0] prev;
    m_addr = '0;
    m_data = '0;
    for (int i = 0; i < 3; i++) m_reg[i] = RSTV[i];

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ack == 1'b0, "R1", "ack after reset", {15'd0, ack}, 16'd0);
    chk(dout == 16'h0000, "R1", "dout after reset", dout, 16'h0000);
    // R1 address latch is zero: a bare read stage returns the identity
    run_stage(3, 16'hFFFF, g);
    chk(g == ID_V, "R1", "read with reset address latch", g, ID_V);
    // R1 data latch is zero: commit straight to 0x0010 writes 0x0000
    run_stage(0, 16'h0010, g);
    run_stage(2, 16'hBEEF, g);
    run_stage(3, 16'h0000, g);
    chk(g == 16'h0000, "R1", "commit of reset data latch", g, 16'h0000);

    // R6 reset values of the other registers, then write/readback (R5)
    check_bank("R6");
    do_write(16'h0010, 16'hC3C3);
    do_write(16'h1005, 16'h0001);
    do_write(16'h201F, 16'hFFFF);
    check_bank("R5");

    // R8 identity register ignores commits
    do_write(16'h0000, 16'h5555);
    do_read(16'h0000, "R8");
    check_bank("R8");

    // R9 unimplemented in-range offsets
    do_write(16'h0011, 16'h7777);
    do_write(16'h1004, 16'h7777);
    do_read(16'h0011, "R9");
    do_read(16'h1004, "R9");
    check_bank("R9");

    // R10 above range: no aliasing onto 0x201F or 0x0010
    do_write(16'h2020, 16'h9999);
    do_write(16'hFFFF, 16'h9999);
    do_write(16'h8010, 16'h9999);
    do_read(16'h2020, "R10");
    do_read(16'hFFFF, "R10");
    check_bank("R10");

    // R11 latches persist: new address only, data reused
    do_write(16'h1005, 16'h4242);
    run_stage(0, 16'h0010, g);
    run_stage(2, 16'h0000, g);
    do_read(16'h0010, "R11");
    run_stage(3, 16'h0000, g);
    chk(g == m_read(m_addr), "R11", "bare read reuses address", g, m_read(m_addr));

    // R4 second strobe during a stage waits for ack to fall
    prev = dout;
    @(negedge clk);
    din = 16'h1005;
    req_addr = 1'b1;
    while (!ack) @(negedge clk);
    req_rd = 1'b1;
    @(negedge clk);
    chk(dout == prev, "R4", "read held off during address stage", dout, prev);
    chk(ack == 1'b1, "R4", "ack still high", {15'd0, ack}, 16'd1);
    req_addr = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R4", "ack falls with other strobe high", {15'd0, ack}, 16'd0);
    m_addr = 16'h1005;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!ack && n < 12);
      chk(n == LAT + 1, "R4", "pending strobe starts new stage", 16'(n), 16'(LAT + 1));
    end
    chk(dout == m_read(16'h1005), "R4", "pending read data", dout, m_read(16'h1005));
    req_rd = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R4", "pending read release", {15'd0, ack}, 16'd0);

    // R4 two strobes at once in idle start nothing
    @(negedge clk);
    din = 16'h201F;
    req_addr = 1'b1;
    req_data = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(ack == 1'b0, "R4", "no ack on double strobe", {15'd0, ack}, 16'd0);
    end
    req_addr = 1'b0;
    req_data = 1'b0;
    run_stage(3, 16'h0000, g);
    chk(g == m_read(m_addr), "R4", "latches untouched by double strobe", g, m_read(m_addr));
    run_stage(2, 16'h0000, g);
    check_bank("R4");

    // Near-exhaustive read sweep: stride plus boundary windows
    for (int a = 0; a <= 16'h2040; a += 37) do_read(16'(a), tag_of(16'(a)));
    for (int a = 0; a <= 16'h0012; a++) do_read(16'(a), tag_of(16'(a)));
    for (int a = 16'h200C; a <= 16'h2024; a++) do_read(16'(a), tag_of(16'(a)));
    for (int a = 16'hFFF8; a <= 16'hFFFF; a++) do_read(16'(a), tag_of(16'(a)));

    // Write sweep across the whole 16-bit offset space, each followed by read-back
    for (int a = 0; a <= 16'hFFFF; a += 1031) begin
      do_write(16'(a), 16'(a) ^ 16'h5A5A);
      do_read(16'(a), tag_of(16'(a)));
    end
    for (int i = 0; i < 3; i++) begin
      do_write(OFS[i], OFS[i] ^ 16'hA5A5);
      do_write(OFS[i] + 16'd1, 16'h0BAD);
    end
    check_bank("R6");

    finished = 1'b1;
    finish_run();
  end

endmodule